// File: doc/BRIEF.md
# Path Overhead Byte Inserter

This block produces the three path overhead bytes of an STS-1 / AU-3 path that come from the transmit side's own settings: the path trace byte (J1), the signal label byte (C2) and the path status byte (G1). A frame-position strobe marks the slot of each byte. One clock later the block presents the chosen byte on its output, with a valid flag and a code that says which byte it is. Parity generation (B3) and scrambling are done elsewhere.

The path trace is replayed from a 64-entry buffer that the user loads. The block adds no checksum, so the user stores the trace CRC as part of the 64 bytes. The trace and signal label bytes each come from one of three sources, in falling priority: a user value, a per-channel overhead-access value, or a default value. The upper nibble of the status byte carries the remote error count. The user can replace it with a value of their own or with a forced error code. The lower nibble is passed through from an input.

The strobes form the input stream and the byte with its valid flag forms the output stream. There is no ready signal in either direction. Overhead slots sit at fixed places in the frame and cannot be delayed, so the downstream logic must take every byte in the cycle it is valid. All control and data inputs are plain levels, sampled in the strobe cycle.

Top module: `poh_byte_inserter`

## Requirements
- R1: A cycle with any strobe gives `oh_valid`=1 in the next cycle, and a cycle with no strobe gives `oh_valid`=0 in the next cycle. If strobes coincide, J1 wins over C2 and C2 wins over G1. `oh_kind` is 0 for J1, 1 for C2 and 2 for G1.
- R2: While `j1_ins_en`=1, each J1 strobe outputs one trace entry. Successive J1 strobes output successive entries (index 0, 1, 2, ...).
- R3: The trace index moves forward only on a J1 strobe while insert is enabled. After index 63 it returns to index 0. While insert is disabled the index holds.
- R4: In any cycle where `j1_ins_en` is 1 but was 0 in the previous cycle, the trace restarts at index 0. A J1 strobe in that same cycle outputs index 0.
- R5: While `j1_ins_en`=0, J1 carries `j1_oha_val` if `j1_oha_sel`=1. Otherwise J1 carries the default byte, which is 0x00 when `dflt_sel`=0 and 0xFF when `dflt_sel`=1.
- R6: C2 carries `c2_user` if `c2_ins_en`=1. Otherwise it carries `c2_oha_val` if `c2_oha_sel`=1. Otherwise it carries the default byte defined in R5.
- R7: G1 bits 7:4 carry `rei_cnt`, with any value above 8 saturated to 8.
- R8: With `rei_inhibit`=1 and no forced error, G1 bits 7:4 carry `rei_user`.
- R9: G1 bits 7:4 are 3 only when `rei_force`, `berr_ins_en` and `glob_err_en` are all 1. This takes precedence over R8. If any one of the three is 0, the forced code has no effect.
- R10: G1 bits 3:0 equal `g1_low` as sampled in the strobe cycle.
- R11: After reset, `oh_valid`=0, `oh_byte`=0x00 and `oh_kind`=3. The trace index is 0, and every trace entry is 0x00.
- R12: A trace write (`tr_wr_en`, 6-bit index `tr_wr_addr`) may happen in any cycle. A J1 byte read from the same index in the same cycle carries the entry's old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| j1_stb | input | 1 | J1 slot strobe |
| c2_stb | input | 1 | C2 slot strobe |
| g1_stb | input | 1 | G1 slot strobe |
| j1_ins_en | input | 1 | Replay trace buffer on J1 |
| j1_oha_sel | input | 1 | Use overhead-access value for J1 |
| j1_oha_val | input | 8 | Overhead-access value for J1 |
| c2_ins_en | input | 1 | Use user value for C2 |
| c2_user | input | 8 | User signal label |
| c2_oha_sel | input | 1 | Use overhead-access value for C2 |
| c2_oha_val | input | 8 | Overhead-access value for C2 |
| dflt_sel | input | 1 | Default byte: 0x00 or 0xFF |
| rei_cnt | input | 4 | Received parity block error count |
| rei_inhibit | input | 1 | Replace count with user nibble |
| rei_user | input | 4 | User nibble for G1 bits 7:4 |
| rei_force | input | 1 | Request forced error code |
| berr_ins_en | input | 1 | Bit-error insert enable |
| glob_err_en | input | 1 | Global error-insert enable |
| g1_low | input | 4 | G1 bits 3:0 pass-through |
| tr_wr_en | input | 1 | Trace buffer write strobe |
| tr_wr_addr | input | 6 | Trace entry index |
| tr_wr_data | input | 8 | Trace entry data |
| oh_valid | output | 1 | Output byte valid |
| oh_kind | output | 2 | Byte identity (0 J1, 1 C2, 2 G1) |
| oh_byte | output | 8 | Overhead byte |

## Verification
The bench runs more than 64 J1 frames in a row to reach the wrap from index 63 to 0. A design that stops at the last entry or skips index 0 on the way round would send a shifted trace.

It also turns trace insert off and back on in the same cycle as a J1 strobe. A design that registers the rising edge one cycle late would send the old index instead of index 0 on the first frame after re-enable.

The forced error code is tried with each of its three enables dropped in turn, and together with the inhibit, so that a wrong gating term or a wrong precedence shows up as a wrong nibble. Remote error counts above 8 are driven to catch a missing saturation. Trace writes land on the index being read in the same cycle, to catch a read that returns the new data instead of the old.

// File: rtl/poh_pkg.sv
package poh_pkg;

  typedef enum logic [1:0] {
    OH_J1   = 2'd0,
    OH_C2   = 2'd1,
    OH_G1   = 2'd2,
    OH_NONE = 2'd3
  } oh_kind_e;

  // Fallback byte when no user or access source is selected.
  function automatic logic [7:0] fill_byte(input logic sel);
    return sel ? 8'hFF : 8'h00;
  endfunction

endpackage

// File: rtl/poh_trace_store.sv
module poh_trace_store #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          ins_en,
  input  logic          adv,
  output logic [W-1:0]  rd_data
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_eff;
  logic          en_q;
  logic          en_rise;

  assign en_rise = ins_en & ~en_q;
  assign ptr_eff = en_rise ? '0 : ptr_q;
  assign rd_data = mem_q[ptr_eff];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem_q[e] <= '0;
      else if (wr_en && wr_addr == AW'(e))
        mem_q[e] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= ins_en;
      if (adv)
        ptr_q <= (ptr_eff == LAST) ? '0 : ptr_eff + 1'b1;
      else if (en_rise)
        ptr_q <= '0;
    end
  end

  // R3
  trace_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !en_rise && ptr_q == LAST) |=> ptr_q == '0);

  // R3
  trace_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !en_rise) |=> $stable(ptr_q));

  // R4
  trace_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && adv) |=> ptr_q == AW'(1));

endmodule

// File: rtl/poh_src_sel.sv
module poh_src_sel
  import poh_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         ins_en,
  input  logic [W-1:0] user_val,
  input  logic         oha_sel,
  input  logic [W-1:0] oha_val,
  input  logic         dflt_sel,
  output logic [W-1:0] out_val
);

  logic [W-1:0] dflt_val;

  assign dflt_val = W'(fill_byte(dflt_sel)) | (dflt_sel ? {W{1'b1}} : '0);

  always_comb begin
    if (ins_en)
      out_val = user_val;
    else if (oha_sel)
      out_val = oha_val;
    else
      out_val = dflt_val;
  end

endmodule

// File: rtl/poh_rei_nibble.sv
module poh_rei_nibble #(
  parameter int W          = 4,
  parameter int MAX_CNT    = 8,
  parameter int FORCE_CODE = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic         inhibit,
  input  logic [W-1:0] user_val,
  input  logic         force_req,
  input  logic         berr_en,
  input  logic         glob_en,
  output logic [W-1:0] nib
);

  localparam logic [W-1:0] MAXV = W'(MAX_CNT);
  localparam logic [W-1:0] FRCV = W'(FORCE_CODE);

  logic         force_act;
  logic [W-1:0] cnt_sat;

  assign force_act = force_req & berr_en & glob_en;
  assign cnt_sat   = (cnt > MAXV) ? MAXV : cnt;

  always_comb begin
    if (force_act)
      nib = FRCV;
    else if (inhibit)
      nib = user_val;
    else
      nib = cnt_sat;
  end

  // R7
  rei_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_req && !inhibit) |-> nib <= MAXV);

  // R9
  rei_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!berr_en && inhibit) |-> nib == user_val);

endmodule

// File: rtl/poh_byte_inserter.sv
module poh_byte_inserter
  import poh_pkg::*;
#(
  parameter int TRACE_DEPTH = 64,
  parameter int BYTE_W      = 8,
  parameter int REI_W       = 4,
  parameter int REI_MAX     = 8,
  parameter int REI_FORCE   = 3,
  localparam int TAW        = $clog2(TRACE_DEPTH),
  localparam int LOW_W      = BYTE_W - REI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              j1_stb,
  input  logic              c2_stb,
  input  logic              g1_stb,
  input  logic              j1_ins_en,
  input  logic              j1_oha_sel,
  input  logic [BYTE_W-1:0] j1_oha_val,
  input  logic              c2_ins_en,
  input  logic [BYTE_W-1:0] c2_user,
  input  logic              c2_oha_sel,
  input  logic [BYTE_W-1:0] c2_oha_val,
  input  logic              dflt_sel,
  input  logic [REI_W-1:0]  rei_cnt,
  input  logic              rei_inhibit,
  input  logic [REI_W-1:0]  rei_user,
  input  logic              rei_force,
  input  logic              berr_ins_en,
  input  logic              glob_err_en,
  input  logic [LOW_W-1:0]  g1_low,
  input  logic              tr_wr_en,
  input  logic [TAW-1:0]    tr_wr_addr,
  input  logic [BYTE_W-1:0] tr_wr_data,
  output logic              oh_valid,
  output logic [1:0]        oh_kind,
  output logic [BYTE_W-1:0] oh_byte
);

  logic              sel_j1, sel_c2, sel_g1, any_stb;
  logic [BYTE_W-1:0] trace_byte, j1_byte, c2_byte, g1_byte;
  logic [REI_W-1:0]  rei_nib;
  logic              valid_q;
  oh_kind_e          kind_q;
  logic [BYTE_W-1:0] byte_q;

  assign sel_j1  = j1_stb;
  assign sel_c2  = c2_stb & ~j1_stb;
  assign sel_g1  = g1_stb & ~j1_stb & ~c2_stb;
  assign any_stb = j1_stb | c2_stb | g1_stb;

  poh_trace_store #(.DEPTH(TRACE_DEPTH), .W(BYTE_W)) u_trace (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tr_wr_en),
    .wr_addr (tr_wr_addr),
    .wr_data (tr_wr_data),
    .ins_en  (j1_ins_en),
    .adv     (sel_j1 & j1_ins_en),
    .rd_data (trace_byte)
  );

  poh_src_sel #(.W(BYTE_W)) u_j1_sel (
    .ins_en   (j1_ins_en),
    .user_val (trace_byte),
    .oha_sel  (j1_oha_sel),
    .oha_val  (j1_oha_val),
    .dflt_sel (dflt_sel),
    .out_val  (j1_byte)
  );

  poh_src_sel #(.W(BYTE_W)) u_c2_sel (
    .ins_en   (c2_ins_en),
    .user_val (c2_user),
    .oha_sel  (c2_oha_sel),
    .oha_val  (c2_oha_val),
    .dflt_sel (dflt_sel),
    .out_val  (c2_byte)
  );

  poh_rei_nibble #(.W(REI_W), .MAX_CNT(REI_MAX), .FORCE_CODE(REI_FORCE)) u_rei (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (rei_cnt),
    .inhibit   (rei_inhibit),
    .user_val  (rei_user),
    .force_req (rei_force),
    .berr_en   (berr_ins_en),
    .glob_en   (glob_err_en),
    .nib       (rei_nib)
  );

  assign g1_byte = {rei_nib, g1_low};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      kind_q  <= OH_NONE;
      byte_q  <= '0;
    end else begin
      valid_q <= any_stb;
      if (sel_j1) begin
        kind_q <= OH_J1;
        byte_q <= j1_byte;
      end else if (sel_c2) begin
        kind_q <= OH_C2;
        byte_q <= c2_byte;
      end else if (sel_g1) begin
        kind_q <= OH_G1;
        byte_q <= g1_byte;
      end
    end
  end

  assign oh_valid = valid_q;
  assign oh_kind  = kind_q;
  assign oh_byte  = byte_q;

  // R1
  strobe_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |=> oh_valid);

  // R1
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_stb |=> !oh_valid);

  // R1
  j1_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    j1_stb |=> oh_kind == 2'd0);

  // R6
  c2_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c2_stb && !j1_stb && c2_ins_en) |=> oh_byte == $past(c2_user));

  // R9
  rei_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_g1 && rei_force && berr_ins_en && glob_err_en)
      |=> oh_byte[BYTE_W-1:LOW_W] == REI_W'(REI_FORCE));

  // R10
  g1_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_g1 |=> oh_byte[LOW_W-1:0] == $past(g1_low));

endmodule

// File: tb/poh_byte_inserter_tb.sv
`timescale 1ns/1ps
module poh_byte_inserter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       j1_stb, c2_stb, g1_stb;
  logic       j1_ins_en, j1_oha_sel, c2_ins_en, c2_oha_sel, dflt_sel;
  logic [7:0] j1_oha_val, c2_user, c2_oha_val, tr_wr_data;
  logic [3:0] rei_cnt, rei_user, g1_low;
  logic       rei_inhibit, rei_force, berr_ins_en, glob_err_en, tr_wr_en;
  logic [5:0] tr_wr_addr;
  logic       oh_valid;
  logic [1:0] oh_kind;
  logic [7:0] oh_byte;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_trace [64];
  int         m_ptr;
  logic       m_prev;

  always #2 clk = ~clk;

  poh_byte_inserter dut_i (
    .clk(clk), .rst_n(rst_n), .j1_stb(j1_stb), .c2_stb(c2_stb), .g1_stb(g1_stb),
    .j1_ins_en(j1_ins_en), .j1_oha_sel(j1_oha_sel), .j1_oha_val(j1_oha_val),
    .c2_ins_en(c2_ins_en), .c2_user(c2_user), .c2_oha_sel(c2_oha_sel),
    .c2_oha_val(c2_oha_val), .dflt_sel(dflt_sel), .rei_cnt(rei_cnt),
    .rei_inhibit(rei_inhibit), .rei_user(rei_user), .rei_force(rei_force),
    .berr_ins_en(berr_ins_en), .glob_err_en(glob_err_en), .g1_low(g1_low),
    .tr_wr_en(tr_wr_en), .tr_wr_addr(tr_wr_addr), .tr_wr_data(tr_wr_data),
    .oh_valid(oh_valid), .oh_kind(oh_kind), .oh_byte(oh_byte)
  );

  function automatic logic [7:0] exp_fill(input logic s);
    return s ? 8'hFF : 8'h00;
  endfunction

  function automatic logic [3:0] exp_rei(input logic [3:0] c, input logic inh,
                                         input logic [3:0] u, input logic f,
                                         input logic b, input logic g);
    if (f && b && g) return 4'd3;
    if (inh) return u;
    return (c > 4'd8) ? 4'd8 : c;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    j1_stb = 0; c2_stb = 0; g1_stb = 0; tr_wr_en = 0;
  endtask

  // Drive is already set up; compute the model result, clock once, compare.
  task automatic step();
    logic       any, rise;
    int         eff;
    logic [1:0] ekind;
    logic [7:0] ebyte;
    string      tag;
    any   = j1_stb | c2_stb | g1_stb;
    rise  = j1_ins_en && !m_prev;
    eff   = rise ? 0 : m_ptr;
    ekind = 2'd3;
    ebyte = 8'h00;
    tag   = "R1";
    if (j1_stb) begin
      ekind = 2'd0;
      if (j1_ins_en) begin ebyte = m_trace[eff]; tag = "R2 R3 R4 R12"; end
      else begin ebyte = j1_oha_sel ? j1_oha_val : exp_fill(dflt_sel); tag = "R5"; end
    end else if (c2_stb) begin
      ekind = 2'd1;
      ebyte = c2_ins_en ? c2_user : (c2_oha_sel ? c2_oha_val : exp_fill(dflt_sel));
      tag = "R6";
    end else if (g1_stb) begin
      ekind = 2'd2;
      ebyte = {exp_rei(rei_cnt, rei_inhibit, rei_user, rei_force, berr_ins_en, glob_err_en), g1_low};
      tag = "R7 R8 R9 R10";
    end
    if (j1_stb && j1_ins_en) m_ptr = (eff + 1) % 64;
    else if (rise) m_ptr = 0;
    m_prev = j1_ins_en;
    if (tr_wr_en) m_trace[tr_wr_addr] = tr_wr_data;
    @(posedge clk);
    @(negedge clk);
    check("R1 valid", {31'd0, oh_valid}, {31'd0, any});
    if (any) begin
      check({"R1 kind ", tag}, {30'd0, oh_kind}, {30'd0, ekind});
      check(tag, {24'd0, oh_byte}, {24'd0, ebyte});
    end
    idle_inputs();
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    rst_n = 0; idle_inputs();
    j1_ins_en = 0; j1_oha_sel = 0; c2_ins_en = 0; c2_oha_sel = 0; dflt_sel = 0;
    j1_oha_val = 0; c2_user = 0; c2_oha_val = 0; tr_wr_data = 0; tr_wr_addr = 0;
    rei_cnt = 0; rei_user = 0; g1_low = 0; rei_inhibit = 0; rei_force = 0;
    berr_ins_en = 0; glob_err_en = 0;
    for (int i = 0; i < 64; i++) m_trace[i] = 8'h00;
    m_ptr = 0; m_prev = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    check("R11 valid", {31'd0, oh_valid}, 32'd0);
    check("R11 kind", {30'd0, oh_kind}, 32'd3);
    check("R11 byte", {24'd0, oh_byte}, 32'd0);

    // R11 R4: first J1 after enabling reads entry 0, which is still 0x00
    j1_ins_en = 1; j1_stb = 1; step();

    // R12: load a distinct trace
    j1_ins_en = 0;
    for (int i = 0; i < 64; i++) begin
      tr_wr_en = 1; tr_wr_addr = 6'(i); tr_wr_data = 8'(i * 7 + 8'h31); step();
    end

    // R2 R3: run past the wrap
    j1_ins_en = 1;
    for (int i = 0; i < 70; i++) begin j1_ins_en = 1; j1_stb = 1; step(); end

    // R4: drop and re-enable with a strobe in the rising cycle
    j1_ins_en = 0; j1_stb = 1; step();
    j1_ins_en = 1; j1_stb = 1; step();
    j1_ins_en = 1; j1_stb = 1; step();

    // R12: write the entry being read in the same cycle
    j1_ins_en = 1; j1_stb = 1; tr_wr_en = 1; tr_wr_addr = 6'd2; tr_wr_data = 8'hC3; step();

    // R5 default and access values
    j1_ins_en = 0; j1_oha_sel = 0; dflt_sel = 1; j1_stb = 1; step();
    dflt_sel = 0; j1_stb = 1; step();
    j1_oha_sel = 1; j1_oha_val = 8'h5A; j1_stb = 1; step();

    // R7 saturation, R8, R9 gating
    rei_cnt = 4'd8; g1_low = 4'h9; g1_stb = 1; step();
    rei_cnt = 4'd13; g1_stb = 1; step();
    rei_inhibit = 1; rei_user = 4'hE; g1_stb = 1; step();
    rei_force = 1; berr_ins_en = 1; glob_err_en = 0; g1_stb = 1; step();
    glob_err_en = 1; berr_ins_en = 0; g1_stb = 1; step();
    berr_ins_en = 1; g1_stb = 1; step();
    rei_force = 0; g1_stb = 1; step();

    // R1 simultaneous strobes
    c2_stb = 1; g1_stb = 1; step();
    j1_stb = 1; c2_stb = 1; g1_stb = 1; step();

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 15));
      j1_stb = (r < 4); c2_stb = (r >= 3 && r < 7); g1_stb = (r >= 6 && r < 10);
      if ($urandom_range(0, 40) == 0) j1_ins_en = ~j1_ins_en;
      j1_oha_sel = 1'($urandom); j1_oha_val = 8'($urandom);
      c2_ins_en = 1'($urandom); c2_user = 8'($urandom);
      c2_oha_sel = 1'($urandom); c2_oha_val = 8'($urandom);
      dflt_sel = 1'($urandom); rei_cnt = 4'($urandom);
      rei_inhibit = 1'($urandom); rei_user = 4'($urandom);
      rei_force = 1'($urandom); berr_ins_en = 1'($urandom);
      glob_err_en = 1'($urandom); g1_low = 4'($urandom);
      tr_wr_en = ($urandom_range(0, 3) == 0);
      tr_wr_addr = 6'($urandom); tr_wr_data = 8'($urandom);
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule